// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits on the memory path of a host bridge. It sorts every access below the 1 MiB boundary to one of two targets: main DRAM or the PCI bus. It also marks a write as blocked when the region it hits is set to read-only. Software sets the routing through a byte-wide configuration write port, with one register address per byte.

Three kinds of region are decoded:

- The top 64 KiB (system firmware) is steered by one two-bit attribute field.
- Twelve 16 KiB expansion windows above 0xC0000 each take a two-bit field. The fields are packed two to a byte.
- The 128 KiB video window at 0xA0000 is opened to DRAM by a control byte. Whether the window opens can depend on the system management mode input.

Everything else below 1 MiB goes to DRAM. The decode is purely combinational from the address, the write flag and the mode input. Register writes take effect at the next clock edge.

Top module: `legacy_mem_decode`

## Requirements
- R1: Any address below 0xA0000 routes to DRAM for reads and writes, whatever the register contents.
- R2: Addresses 0xF0000 to 0xFFFFF use the attribute held in bits [5:4] of the register at config offset 0x59.
- R3: Expansion region i (i = 0..11) covers 0xC0000 + i*0x4000 up to 0x4000 bytes. Its attribute lives in the register at offset 0x5A + i/2: bits [1:0] for even i and bits [5:4] for odd i.
- R4: Attribute encoding: 3 = DRAM for reads and writes; 1 = DRAM for reads with writes blocked; 0 and 2 = PCI bus for reads and writes.
- R5: A write to a region with attribute 1 raises write_blocked and drops both route outputs. In every cycle exactly one of route_dram, route_pci and write_blocked is high, and write_blocked is only ever high on a write.
- R6: The window 0xA0000 to 0xBFFFF routes to DRAM when bit 6 of the control register at offset 0x72 is set, or when smm_active is high and bit 3 is set. Otherwise it routes to PCI. Reads and writes are treated alike.
- R7: A change of smm_active changes the window routing in the same cycle, with no clock edge needed.
- R8: After reset all attribute fields are 0, so every attribute region goes to PCI. The control register reads as 0x02, so the window goes to PCI.
- R9: A configuration write takes effect at the clock edge that samples it. The decode in the cycle of the write still uses the old value. Writes to offsets other than 0x59, 0x5A to 0x5F and 0x72 change nothing.
- R10: Only the bits named in R2, R3 and R6 affect routing. All other bits of those registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| smm_active | input | 1 | System management mode active |
| acc_addr | input | 20 | Access physical address |
| acc_write | input | 1 | Access is a write (0 = read) |
| route_dram | output | 1 | Access goes to DRAM |
| route_pci | output | 1 | Access goes to the PCI bus |
| write_blocked | output | 1 | Write hit a read-only region and is dropped |

## Verification
Two events can land in the same cycle: a configuration write that retargets a region, and an access to that region. The bench drives both together. It samples the outputs before the capturing edge, where they must still reflect the old attribute, and again just after the edge, where they must reflect the new one. The window case has a second overlap. A write to the control byte and an smm_active toggle are combined, and the routing is judged against the control value then in force and the live mode level.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

   typedef enum logic [1:0] {
      ATTR_BUS_A  = 2'd0,
      ATTR_RDONLY = 2'd1,
      ATTR_BUS_B  = 2'd2,
      ATTR_RDWR   = 2'd3
   } attr_e;

   typedef struct packed {
      logic dram;
      logic pci;
      logic blocked;
   } route_t;

   function automatic route_t attr_to_route(input logic [1:0] attr, input logic is_wr);
      route_t r;
      r = '0;
      case (attr_e'(attr))
         ATTR_RDWR:   r.dram = 1'b1;
         ATTR_RDONLY: begin
            r.dram    = ~is_wr;
            r.blocked = is_wr;
         end
         default:     r.pci = 1'b1;
      endcase
      return r;
   endfunction

   function automatic route_t plain_route(input logic to_dram);
      route_t r;
      r.dram    = to_dram;
      r.pci     = ~to_dram;
      r.blocked = 1'b0;
      return r;
   endfunction

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs #(
   parameter int CFG_AW       = 8,
   parameter int CFG_DW       = 8,
   parameter int NUM_REGIONS  = 12,
   parameter int ATTR_W       = 2,
   parameter int NIBBLE_W     = 4,
   parameter int HI_OFS       = 'h59,
   parameter int HI_LSB       = 4,
   parameter int EXP_OFS      = 'h5A,
   parameter int WIN_OFS      = 'h72,
   parameter logic [CFG_DW-1:0] WIN_RST = 8'h02,
   parameter int WIN_OPEN_BIT = 6,
   parameter int WIN_SMM_BIT  = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we,
   input  logic [CFG_AW-1:0]                  addr,
   input  logic [CFG_DW-1:0]                  wdata,
   output logic [ATTR_W-1:0]                  hi_attr,
   output logic [NUM_REGIONS-1:0][ATTR_W-1:0] exp_attr,
   output logic                               win_open_en,
   output logic                               win_smm_en
);

   localparam logic [CFG_AW-1:0] HI_A  = CFG_AW'(HI_OFS);
   localparam logic [CFG_AW-1:0] WIN_A = CFG_AW'(WIN_OFS);

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_attr <= '0;
      else if (we && addr == HI_A)
         hi_attr <= wdata[HI_LSB +: ATTR_W];
   end

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_exp
      localparam logic [CFG_AW-1:0] BYTE_A = CFG_AW'(EXP_OFS + i / 2);
      localparam int                LSB    = (i % 2) * NIBBLE_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            exp_attr[i] <= '0;
         else if (we && addr == BYTE_A)
            exp_attr[i] <= wdata[LSB +: ATTR_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_open_en <= WIN_RST[WIN_OPEN_BIT];
         win_smm_en  <= WIN_RST[WIN_SMM_BIT];
      end else if (we && addr == WIN_A) begin
         win_open_en <= wdata[WIN_OPEN_BIT];
         win_smm_en  <= wdata[WIN_SMM_BIT];
      end
   end

endmodule

// File: rtl/lmd_attr_lookup.sv
module lmd_attr_lookup #(
   parameter int ADDR_W      = 20,
   parameter int NUM_REGIONS = 12,
   parameter int REGION_LOG2 = 14,
   parameter int ATTR_W      = 2,
   parameter logic [ADDR_W-1:0] EXP_BASE = 20'hC0000,
   parameter logic [ADDR_W-1:0] HI_BASE  = 20'hF0000
) (
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [ATTR_W-1:0]                  hi_attr,
   input  logic [NUM_REGIONS-1:0][ATTR_W-1:0] exp_attr,
   output logic                               hit,
   output logic [ATTR_W-1:0]                  attr
);

   localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
   localparam logic [ADDR_W-1:0] EXP_SPAN = ADDR_W'(NUM_REGIONS) << REGION_LOG2;
   localparam logic [ADDR_W-1:0] EXP_END  = EXP_BASE + EXP_SPAN;

   logic [ADDR_W-1:0]      off;
   logic [IDX_W-1:0]       idx;
   logic                   in_exp, in_hi;
   logic [NUM_REGIONS-1:0] sel;
   logic [ATTR_W-1:0]      exp_sel;
   logic                   unused_off;

   assign off        = addr - EXP_BASE;
   assign idx        = off[REGION_LOG2 +: IDX_W];
   assign unused_off = ^off;
   assign in_exp     = (addr >= EXP_BASE) && (addr < EXP_END);
   assign in_hi      = (addr >= HI_BASE);

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
      assign sel[i] = in_exp && (idx == IDX_W'(i));
   end

   always_comb begin
      exp_sel = '0;
      for (int i = 0; i < NUM_REGIONS; i++)
         if (sel[i]) exp_sel = exp_sel | exp_attr[i];
   end

   assign hit  = in_hi | in_exp;
   assign attr = in_hi ? hi_attr : exp_sel;

endmodule

// File: rtl/lmd_win_ctrl.sv
module lmd_win_ctrl #(
   parameter int ADDR_W   = 20,
   parameter int WIN_LOG2 = 17,
   parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              smm_active,
   input  logic              open_en,
   input  logic              smm_en,
   output logic              hit,
   output logic              to_dram
);

   assign hit     = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
   assign to_dram = open_en | (smm_active & smm_en);

endmodule

// File: rtl/legacy_mem_decode.sv
module legacy_mem_decode
   import lmd_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int CFG_AW       = 8,
   parameter int CFG_DW       = 8,
   parameter int NUM_REGIONS  = 12,
   parameter int REGION_LOG2  = 14,
   parameter int ATTR_W       = 2,
   parameter int NIBBLE_W     = 4,
   parameter logic [ADDR_W-1:0] EXP_BASE = 20'hC0000,
   parameter logic [ADDR_W-1:0] HI_BASE  = 20'hF0000,
   parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000,
   parameter int WIN_LOG2     = 17,
   parameter int HI_OFS       = 'h59,
   parameter int HI_LSB       = 4,
   parameter int EXP_OFS      = 'h5A,
   parameter int WIN_OFS      = 'h72,
   parameter logic [CFG_DW-1:0] WIN_RST = 8'h02,
   parameter int WIN_OPEN_BIT = 6,
   parameter int WIN_SMM_BIT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              smm_active,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              route_dram,
   output logic              route_pci,
   output logic              write_blocked
);

   localparam int NUM_EXP_REGS = (NUM_REGIONS + 1) / 2;

   initial begin : p_param_chk
      chk_even_regions: assert (NUM_REGIONS % 2 == 0)
         else $error("NUM_REGIONS must be even");
      chk_attr_fits: assert (ATTR_W <= NIBBLE_W && HI_LSB + ATTR_W <= CFG_DW)
         else $error("attribute field does not fit");
      chk_bits: assert (WIN_OPEN_BIT < CFG_DW && WIN_SMM_BIT < CFG_DW)
         else $error("window control bit out of range");
      chk_exp_span: assert (EXP_BASE + (NUM_REGIONS << REGION_LOG2) <= HI_BASE)
         else $error("expansion regions overlap firmware region");
      chk_win: assert (WIN_BASE + (1 << WIN_LOG2) <= EXP_BASE)
         else $error("window overlaps expansion regions");
      chk_regs: assert (EXP_OFS + NUM_EXP_REGS <= (1 << CFG_AW))
         else $error("register block exceeds config space");
   end

   logic [ATTR_W-1:0]                  hi_attr;
   logic [NUM_REGIONS-1:0][ATTR_W-1:0] exp_attr;
   logic                               win_open_en, win_smm_en;
   logic                               attr_hit, win_hit, win_dram;
   logic [ATTR_W-1:0]                  attr;
   route_t                             route;

   lmd_cfg_regs #(
      .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .NUM_REGIONS(NUM_REGIONS),
      .ATTR_W(ATTR_W), .NIBBLE_W(NIBBLE_W), .HI_OFS(HI_OFS), .HI_LSB(HI_LSB),
      .EXP_OFS(EXP_OFS), .WIN_OFS(WIN_OFS), .WIN_RST(WIN_RST),
      .WIN_OPEN_BIT(WIN_OPEN_BIT), .WIN_SMM_BIT(WIN_SMM_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .hi_attr(hi_attr), .exp_attr(exp_attr),
      .win_open_en(win_open_en), .win_smm_en(win_smm_en)
   );

   lmd_attr_lookup #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .REGION_LOG2(REGION_LOG2),
      .ATTR_W(ATTR_W), .EXP_BASE(EXP_BASE), .HI_BASE(HI_BASE)
   ) u_lookup (
      .addr(acc_addr), .hi_attr(hi_attr), .exp_attr(exp_attr),
      .hit(attr_hit), .attr(attr)
   );

   lmd_win_ctrl #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
   ) u_win (
      .addr(acc_addr), .smm_active(smm_active),
      .open_en(win_open_en), .smm_en(win_smm_en),
      .hit(win_hit), .to_dram(win_dram)
   );

   always_comb begin
      if (win_hit)
         route = plain_route(win_dram);
      else if (attr_hit)
         route = attr_to_route(attr, acc_write);
      else
         route = plain_route(1'b1);
   end

   assign route_dram    = route.dram;
   assign route_pci     = route.pci;
   assign write_blocked = route.blocked;

endmodule

// File: rtl/lmd_chk.sv
module lmd_chk #(
   parameter int ADDR_W       = 20,
   parameter int CFG_AW       = 8,
   parameter int CFG_DW       = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000,
   parameter int WIN_LOG2     = 17,
   parameter int WIN_OFS      = 'h72,
   parameter logic [CFG_DW-1:0] WIN_RST = 8'h02,
   parameter int WIN_OPEN_BIT = 6,
   parameter int WIN_SMM_BIT  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [CFG_DW-1:0] cfg_wdata,
   input logic              smm_active,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_write,
   input logic              route_dram,
   input logic              route_pci,
   input logic              write_blocked,
   input logic              win_open_en,
   input logic              win_smm_en
);

   localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(1 << WIN_LOG2);

   logic in_win;
   assign in_win = ({1'b0, acc_addr} >= {1'b0, WIN_BASE}) && ({1'b0, acc_addr} < WIN_END);

   assert_one_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({route_dram, route_pci, write_blocked}) == 1);

   assert_block_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      write_blocked |-> acc_write);

   assert_low_dram_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr < WIN_BASE) |-> route_dram);

   assert_win_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && win_open_en) |-> route_dram);

   assert_win_smm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !win_open_en && win_smm_en) |-> (route_dram == smm_active));

   assert_wr_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_we) && $past(cfg_addr) == CFG_AW'(WIN_OFS))
      |-> (win_open_en == $past(cfg_wdata[WIN_OPEN_BIT]) &&
           win_smm_en  == $past(cfg_wdata[WIN_SMM_BIT])));

   assert_reset_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (win_open_en == WIN_RST[WIN_OPEN_BIT] &&
                        win_smm_en  == WIN_RST[WIN_SMM_BIT]));

endmodule

bind legacy_mem_decode lmd_chk #(
   .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .WIN_BASE(WIN_BASE),
   .WIN_LOG2(WIN_LOG2), .WIN_OFS(WIN_OFS), .WIN_RST(WIN_RST),
   .WIN_OPEN_BIT(WIN_OPEN_BIT), .WIN_SMM_BIT(WIN_SMM_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_addr(acc_addr),
   .acc_write(acc_write), .route_dram(route_dram), .route_pci(route_pci),
   .write_blocked(write_blocked), .win_open_en(win_open_en), .win_smm_en(win_smm_en)
);

// File: tb/legacy_mem_decode_tb.sv
module legacy_mem_decode_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        smm_active = 1'b0;
   logic [19:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        route_dram, route_pci, write_blocked;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] sh [0:255];

   always #4 clk = ~clk;

   legacy_mem_decode u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_addr(acc_addr),
      .acc_write(acc_write), .route_dram(route_dram), .route_pci(route_pci),
      .write_blocked(write_blocked)
   );

   // expected {dram, pci, blocked}
   function automatic logic [2:0] model(input logic [19:0] a, input logic wr, input logic smm);
      logic [1:0] at;
      logic [7:0] b;
      int         i;
      if (a >= 20'hF0000) begin
         at = sh[8'h59][5:4];
      end else if (a >= 20'hC0000) begin
         i  = int'((a - 20'hC0000) >> 14);
         b  = sh[8'h5A + 8'(i / 2)];
         at = (i % 2 == 1) ? b[5:4] : b[1:0];
      end else if (a >= 20'hA0000) begin
         return (sh[8'h72][6] || (smm && sh[8'h72][3])) ? 3'b100 : 3'b010;
      end else begin
         return 3'b100;
      end
      case (at)
         2'd3:    return 3'b100;
         2'd1:    return wr ? 3'b001 : 3'b100;
         default: return 3'b010;
      endcase
   endfunction

   task automatic check(input string tag, input logic [2:0] exp);
      logic [2:0] got;
      got = {route_dram, route_pci, write_blocked};
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h wr=%b smm=%b got=%b exp=%b",
                  tag, acc_addr, acc_write, smm_active, got, exp);
      end
   endtask

   task automatic probe(input string tag, input logic [19:0] a, input logic wr);
      @(negedge clk);
      acc_addr  = a;
      acc_write = wr;
      #1;
      check(tag, model(a, wr, smm_active));
   endtask

   task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      sh[a] = d;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 256; i++) sh[i] = 8'h00;
      sh[8'h72] = 8'h02;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R8: every attribute region and the window go to PCI
      probe("R8 hi", 20'hF8000, 1'b0);
      probe("R8 exp0", 20'hC0000, 1'b1);
      probe("R8 exp11", 20'hEFFFF, 1'b0);
      probe("R8 win", 20'hA0000, 1'b0);
      @(negedge clk);
      acc_addr = 20'hB0000; acc_write = 1'b0; #1;
      check("R8 win pci", 3'b010);
   endtask

   task automatic t_low;
      cfg_wr(8'h72, 8'h00);
      probe("R1 zero rd", 20'h00000, 1'b0);
      probe("R1 zero wr", 20'h00000, 1'b1);
      probe("R1 top rd", 20'h9FFFF, 1'b0);
      probe("R1 top wr", 20'h9FFFF, 1'b1);
   endtask

   task automatic t_hi;
      for (int v = 0; v < 4; v++) begin
         cfg_wr(8'h59, 8'(v << 4));
         probe("R2 R4 lo rd", 20'hF0000, 1'b0);
         probe("R2 R4 lo wr", 20'hF0000, 1'b1);
         probe("R2 R4 hi wr", 20'hFFFFF, 1'b1);
      end
   endtask

   task automatic t_exp;
      for (int p = 0; p < 2; p++) begin
         for (int r = 0; r < 6; r++) begin
            logic [1:0] e, o;
            e = 2'((2 * r + p) % 4);
            o = 2'((2 * r + 1 + p) % 4);
            cfg_wr(8'h5A + 8'(r), {2'b00, o, 2'b00, e});
         end
         for (int i = 0; i < 12; i++) begin
            logic [19:0] base;
            base = 20'hC0000 + 20'(i * 'h4000);
            probe("R3 R4 first rd", base, 1'b0);
            probe("R3 R5 first wr", base, 1'b1);
            probe("R3 last wr", base + 20'h3FFF, 1'b1);
         end
      end
   endtask

   task automatic t_window;
      logic [7:0] ctl [0:3];
      ctl[0] = 8'h02; ctl[1] = 8'h40; ctl[2] = 8'h08; ctl[3] = 8'h48;
      for (int c = 0; c < 4; c++) begin
         cfg_wr(8'h72, ctl[c]);
         for (int s = 0; s < 2; s++) begin
            smm_active = s[0];
            probe("R6 rd", 20'hA0000, 1'b0);
            probe("R6 wr", 20'hBFFFF, 1'b1);
         end
      end
      smm_active = 1'b0;
   endtask

   task automatic t_smm_same_cycle;
      cfg_wr(8'h72, 8'h08);
      @(negedge clk);
      acc_addr = 20'hA8000; acc_write = 1'b1; smm_active = 1'b0; #1;
      check("R7 smm low", 3'b010);
      smm_active = 1'b1; #1;
      check("R7 smm rise", 3'b100);
      smm_active = 1'b0; #1;
      check("R7 smm fall", 3'b010);
      // control write lands while smm is high: new value plus live mode
      @(negedge clk);
      smm_active = 1'b1;
      cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h00; #1;
      check("R7 R9 before edge", 3'b100);
      @(posedge clk); #1;
      sh[8'h72] = 8'h00;
      check("R7 R9 after edge", 3'b010);
      @(negedge clk);
      cfg_we = 1'b0; smm_active = 1'b0;
   endtask

   task automatic t_latency;
      cfg_wr(8'h5A, 8'h00);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h03;
      acc_addr = 20'hC0000; acc_write = 1'b0; #1;
      check("R9 old value", 3'b010);
      @(posedge clk); #1;
      sh[8'h5A] = 8'h03;
      check("R9 new value", 3'b100);
      @(negedge clk) cfg_we = 1'b0;
   endtask

   task automatic t_ignored;
      // R10: bits outside the fields have no effect
      cfg_wr(8'h59, 8'hCF);
      probe("R10 hi field 0", 20'hF4000, 1'b0);
      cfg_wr(8'h5B, 8'hCC);
      probe("R10 exp even", 20'hC8000, 1'b0);
      probe("R10 exp odd", 20'hCC000, 1'b1);
      cfg_wr(8'h72, 8'hB7);
      smm_active = 1'b1;
      probe("R10 ctl closed", 20'hA4000, 1'b0);
      smm_active = 1'b0;
      // R9: other offsets leave decode unchanged
      cfg_wr(8'h59, 8'h10);
      cfg_wr(8'h72, 8'h40);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 8'hFF;
      cfg_addr = 8'h58; @(negedge clk);
      cfg_addr = 8'h60; @(negedge clk);
      cfg_addr = 8'h71; @(negedge clk);
      cfg_addr = 8'h73; @(negedge clk);
      cfg_we = 1'b0;
      probe("R9 other ofs hi", 20'hF0000, 1'b1);
      probe("R9 other ofs win", 20'hA0000, 1'b0);
      probe("R9 other ofs exp", 20'hC4000, 1'b0);
   endtask

   logic done = 1'b0;

   initial begin
      t_reset();
      t_low();
      t_hi();
      t_exp();
      t_window();
      t_smm_same_cycle();
      t_latency();
      t_ignored();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule